// File: doc/BRIEF.md
# Three-Bit-Coded 32-Bit ALU

This block is a purely combinational arithmetic and logic unit for a single-cycle processor datapath. Two 32-bit operands enter, a 3-bit operation code selects the function, and the block returns a 32-bit result and a flag that is high when that result is all zeros. The instruction decoder drives the code: 010 for address arithmetic (loads, stores, add-immediate) and 110 for the equality comparison behind a branch-if-equal, where the zero flag gives the outcome.

One adder does all the arithmetic. The top code bit does two things: it replaces B with its bitwise complement, and it serves as the adder's carry-in. So 110 computes A + ~B + 1 = A − B. The same mechanism gives set-less-than, which takes the sign bit of that difference, and the AND-NOT and OR-NOT operations. The low two code bits choose which path reaches the output.

There is no clock or state. Operands and code are plain level signals with no handshake: the result follows the inputs within the same cycle, and the surrounding pipeline registers capture it.

Top module: `alu3_core`

## Requirements
- R1: Code 3'b000 gives y = a AND b.
- R2: Code 3'b001 gives y = a OR b.
- R3: Code 3'b010 gives y = a + b modulo 2^32. The carry out is dropped.
- R4: Code 3'b100 gives y = a AND (NOT b).
- R5: Code 3'b101 gives y = a OR (NOT b).
- R6: Code 3'b110 gives y = a − b modulo 2^32.
- R7: Code 3'b111 gives y = 32'h00000001 when bit 31 of (a − b) is 1, and y = 0 otherwise. Signed overflow is not corrected: a = 32'h80000000 with b = 1 yields 0.
- R8: Code 3'b011 gives y = 0 for all operands.
- R9: zero is 1 exactly when all 32 bits of y are 0, for every code.
- R10: With code 3'b110, zero is 1 exactly when a equals b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand, complemented when the code's top bit is set |
| f | input | 3 | Operation code |
| y | output | 32 | Result |
| zero | output | 1 | High when the result is all zeros |

## Verification
On every input change the assertions check the following: the unused code gives zero; set-less-than produces only 0 or 1 and follows the sign of the difference; the AND-type codes match their bitwise definitions; the zero flag tracks the result; and under code 110 the zero flag reports operand equality. The bench's scenarios are needed to show that the adder's arithmetic is exact at the wrap and carry boundaries, including the sum that wraps to zero and the non-corrected set-less-than on overflowing operands. Those scenarios, walked from a fixed vector table and from random operands against an independent reference, cover every code.

// File: rtl/alu3_pkg.sv
package alu3_pkg;
  localparam int CODE_W = 3;

  // output path chosen by the low two code bits
  typedef enum logic [1:0] {
    PATH_AND = 2'b00,
    PATH_OR  = 2'b01,
    PATH_SUM = 2'b10,
    PATH_LT  = 2'b11
  } path_e;

  // full code of the one unused combination
  localparam logic [CODE_W-1:0] CODE_UNUSED = 3'b011;
endpackage

// File: rtl/alu3_binv.sv
module alu3_binv #(
  parameter int W = 32
) (
  input  logic [W-1:0] b_in,
  input  logic         inv,
  output logic [W-1:0] b_out
);
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      assign b_out[gi] = b_in[gi] ^ inv;
    end
  endgenerate
endmodule

// File: rtl/alu3_adder.sv
module alu3_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] z,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W:0] full;
  assign full = {1'b0, x} + {1'b0, z} + {{W{1'b0}}, cin};
  assign sum  = full[W-1:0];
endmodule

// File: rtl/alu3_outsel.sv
module alu3_outsel
  import alu3_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      bx,
  input  logic [W-1:0]      sum,
  input  logic [CODE_W-1:0] code,
  output logic [W-1:0]      y
);
  path_e path;
  assign path = path_e'(code[1:0]);

  always_comb begin
    unique case (path)
      PATH_AND: y = a & bx;
      PATH_OR:  y = a | bx;
      PATH_SUM: y = sum;
      PATH_LT:  y = (code == CODE_UNUSED) ? '0 : {{(W-1){1'b0}}, sum[W-1]};
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/alu3_core.sv
module alu3_core
  import alu3_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [CODE_W-1:0] f,
  output logic [W-1:0]      y,
  output logic              zero
);
  localparam int INV_BIT = CODE_W - 1;

  logic [W-1:0] bx;
  logic [W-1:0] sum;

  alu3_binv #(.W(W)) u_binv (
    .b_in (b),
    .inv  (f[INV_BIT]),
    .b_out(bx)
  );

  // same bit that complements b supplies the +1 of two's complement
  alu3_adder #(.W(W)) u_add (
    .x  (a),
    .z  (bx),
    .cin(f[INV_BIT]),
    .sum(sum)
  );

  alu3_outsel #(.W(W)) u_sel (
    .a   (a),
    .bx  (bx),
    .sum (sum),
    .code(f),
    .y   (y)
  );

  assign zero = ~|y;
endmodule

// File: rtl/alu3_chk.sv
module alu3_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [2:0]   f,
  input logic [W-1:0] y,
  input logic         zero
);
  logic [W-1:0] diff;
  assign diff = a - b;

  always_comb begin
    if (f == 3'b011) begin
      a_r8_unused_zero: assert (y == '0);
    end
    if (f == 3'b111) begin
      a_r7_lt_range: assert (y[W-1:1] == '0);
      a_r7_lt_sign: assert (y[0] == diff[W-1]);
    end
    if (f == 3'b000) begin
      a_r1_and: assert (y == (a & b));
    end
    if (f == 3'b100) begin
      a_r4_and_not: assert (y == (a & ~b));
    end
    if (f == 3'b110) begin
      a_r10_equal: assert (zero == (a == b));
    end
    a_r9_zero_flag: assert (zero == (y == '0));
  end
endmodule

bind alu3_core alu3_chk #(.W(W)) u_chk (
  .a   (a),
  .b   (b),
  .f   (f),
  .y   (y),
  .zero(zero)
);

// File: tb/sim_alu3_core.sv
module sim_alu3_core;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  localparam int NRAND = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [2:0]  f = '0;
  logic [31:0] y;
  logic        zero;

  int n_checks = 0;
  int n_errors = 0;

  // {code, a, b, expected y, expected zero}
  localparam logic [99:0] VEC [NVEC] = '{
    {3'b000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0}, // R1
    {3'b001, 32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0, 1'b0}, // R2
    {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1}, // R3 wrap, R9
    {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0}, // R3
    {3'b100, 32'hFFFF0000, 32'h0F0F0F0F, 32'hF0F00000, 1'b0}, // R4
    {3'b101, 32'h00000000, 32'hFFFFFFFF, 32'h00000000, 1'b1}, // R5, R9
    {3'b101, 32'h00000001, 32'hFFFF0000, 32'h0000FFFF, 1'b0}, // R5
    {3'b110, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0}, // R6
    {3'b110, 32'h12345678, 32'h12345678, 32'h00000000, 1'b1}, // R6, R10
    {3'b111, 32'h00000003, 32'h00000005, 32'h00000001, 1'b0}, // R7
    {3'b111, 32'h00000005, 32'h00000003, 32'h00000000, 1'b1}, // R7
    {3'b111, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 1'b0}, // R7 negative
    {3'b111, 32'h80000000, 32'h00000001, 32'h00000000, 1'b1}, // R7 no overflow fix
    {3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1}, // R8
    {3'b011, 32'h12345678, 32'h00000001, 32'h00000000, 1'b1}, // R8
    {3'b000, 32'hAAAAAAAA, 32'h55555555, 32'h00000000, 1'b1}  // R1, R9
  };

  alu3_core u0 (
    .a   (a),
    .b   (b),
    .f   (f),
    .y   (y),
    .zero(zero)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] ref_y(input logic [2:0] c, input logic [31:0] x, input logic [31:0] w);
    logic [31:0] d;
    d = x - w;
    case (c)
      3'b000:  return x & w;
      3'b001:  return x | w;
      3'b010:  return x + w;
      3'b100:  return x & ~w;
      3'b101:  return x | ~w;
      3'b110:  return d;
      3'b111:  return {31'd0, d[31]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply_check(input logic [2:0] c, input logic [31:0] x, input logic [31:0] w,
                             input logic [31:0] ey, input logic ez, input string req);
    @(posedge clk);
    a <= x;
    b <= w;
    f <= c;
    @(negedge clk);
    n_checks++;
    if (y !== ey || zero !== ez) begin
      n_errors++;
      $display("FAIL %s code=%b a=%h b=%h: y=%h zero=%b expected y=%h zero=%b",
               req, c, x, w, y, zero, ey, ez);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    // reset-time state: all-zero inputs give AND of zeros, R9 zero flag high
    n_checks++;
    if (y !== 32'd0 || zero !== 1'b1) begin
      n_errors++;
      $display("FAIL R9 reset: y=%h zero=%b expected y=00000000 zero=1", y, zero);
    end

    for (int i = 0; i < NVEC; i++) begin
      apply_check(VEC[i][99:97], VEC[i][96:65], VEC[i][64:33], VEC[i][32:1], VEC[i][0], "R1-table");
    end

    // random operands against the reference, every code
    for (int i = 0; i < NRAND; i++) begin
      logic [2:0]  c;
      logic [31:0] x;
      logic [31:0] w;
      logic [31:0] e;
      c = 3'(i % 8);
      x = $urandom;
      w = (i % 16 == 6) ? x : $urandom;
      e = ref_y(c, x, w);
      apply_check(c, x, w, e, (e == 32'd0), "R3/R6/R7 random");
    end

    // directed corners
    apply_check(3'b110, 32'h80000000, 32'h80000000, 32'h0, 1'b1, "R10 equal");
    apply_check(3'b110, 32'h80000000, 32'h00000000, 32'h80000000, 1'b0, "R10 unequal");
    apply_check(3'b111, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h1, 1'b0, "R7 overflow");
    apply_check(3'b010, 32'h80000000, 32'h80000000, 32'h0, 1'b1, "R3 carry drop");
    apply_check(3'b100, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 1'b1, "R4 all ones");
    apply_check(3'b101, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b0, "R5 zeros");
    apply_check(3'b001, 32'h00000000, 32'h00000000, 32'h0, 1'b1, "R2 zeros");
    apply_check(3'b011, 32'h00000000, 32'hFFFFFFFF, 32'h0, 1'b1, "R8 sweep");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule